// File: doc/BRIEF.md
# I2C Master Queue and Interrupt Register Bank

This block is the host-facing register bank of an I2C master controller. A host reaches it through a 32-bit register read/write port. It holds the controller's configuration, timing and command words. It owns two 64-entry queues. Bytes written by the host travel through the transmit queue to the bit engine. Bytes received by the engine travel through the receive queue back to the host. The bit engine itself lies outside this block and connects through plain control pins and two valid/ready streams.

The bank turns three engine conditions into latched interrupt events: the end of a transfer (the engine busy flag falling), the receive level passing a programmable threshold, and the receive queue filling up. Each event has a pending bit and an enable bit, and a single level interrupt output reports any pending event whose enable is set. Pending bits are cleared by writing ones. Two flush bits empty either queue on demand. A soft-reset bit holds both queues and all pending events cleared.

Back-pressure rules: `host_ready` is always high, so every request is taken on the edge where `host_valid` is high. A read answers on the following cycle with `rsp_valid` high. On the transmit stream a word moves on each edge where `tx_valid` and `tx_ready` are both high, and `tx_data` holds steady while `tx_ready` is low. On the receive stream a word moves on each edge where `rx_valid` and `rx_ready` are both high. `rx_ready` drops while the receive queue is full or soft reset is set.

Top module: `i2cm_csr_bank`

## Requirements
- R1: After reset every register reads 0. Config (0x00) keeps bit 31 (soft reset), bit 30 (enable) and bits 19:16 (retry count), timing (0x04) keeps only bit 31 (fast mode), and every other bit of these registers reads 0.
- R2: A write to 0x40 while soft reset is clear pushes {wdata[31] as last-byte marker, wdata[7:0]} into the transmit queue. The queue presents it on `tx_data` as {last, byte} in write order, and a write while 64 entries are held is dropped.
- R3: `rx_ready` is low while the receive queue holds 64 entries, and a word offered then is not stored.
- R4: A read of 0x44 pops the oldest receive entry and returns its 2-bit status in bits 31:30, its parity-error flag in bit 29 and its byte in bits 7:0. With the queue empty it returns 0 and the count stays the same.
- R5: Register 0x0C reports the receive count in bits 22:16 and holds a 6-bit receive threshold in bits 13:8.
- R6: Writing 1 to 0x0C bit 31 empties the receive queue and writing 1 to bit 30 empties the transmit queue, both within two cycles. Both bits always read back as 0.
- R7: When `eng_busy` goes from 1 to 0, pending bit 28 of the status register (0x3C) is set.
- R8: When the receive count rises from at or below the threshold to above it, pending bit 30 is set.
- R9: When the receive count reaches 64, pending bit 31 is set.
- R10: Writing 1 to a status bit clears it and leaves the other pending bits alone. Writing all ones clears every pending bit.
- R11: Pending bits latch whatever the enables at 0x38 (same bit positions) hold, and `irq` is high exactly while some pending bit has its enable set.
- R12: While config bit 31 is set, both queues are empty, all pending bits are clear, `tx_valid` and `rx_ready` are low, and writes to 0x40 are ignored.
- R13: A write to 0x30 holds wdata[30:0] on `cmd_word`, and if wdata[31] is set it pulses `cmd_start` high for one cycle. A read of 0x30 returns `eng_busy` in bit 31 above the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted (always 1) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| tx_valid | output | 1 | Transmit entry available to the engine |
| tx_ready | input | 1 | Engine takes the transmit entry |
| tx_data | output | 9 | Transmit entry {last, byte} |
| rx_valid | input | 1 | Engine offers a receive entry |
| rx_ready | output | 1 | Receive queue accepts an entry |
| rx_data | input | 11 | Receive entry {status[1:0], parity error, byte} |
| eng_busy | input | 1 | Engine busy flag |
| cmd_start | output | 1 | One-cycle start pulse |
| cmd_word | output | 31 | Held command word |
| ctl_reset | output | 1 | Soft reset to the engine |
| ctl_enable | output | 1 | Controller enable |
| ctl_retry | output | 4 | Retry count |
| ctl_fast | output | 1 | Fast bus speed select |
| irq | output | 1 | Level interrupt |

## Verification
The receive-full event is the hardest case to reach, because it needs the engine side to push 64 entries without the host reading any of them. The stimulus does this with a receive-push task run back to back. It then checks that a 65th offer finds `rx_ready` low and leaves the count at 64. The threshold crossing gets the same care: the count is stepped one entry at a time across the programmed level. The pending bit is checked to be clear at the threshold and set only one entry above it. The soft-reset case loads both queues and a pending event first, so that clearing each of them shows up at the ports.

// File: rtl/i2cm_bank_pkg.sv
package i2cm_bank_pkg;

  // Register byte offsets
  localparam logic [7:0] A_CFG  = 8'h00;
  localparam logic [7:0] A_TIM  = 8'h04;
  localparam logic [7:0] A_FCTL = 8'h0C;
  localparam logic [7:0] A_CMD  = 8'h30;
  localparam logic [7:0] A_IEN  = 8'h38;
  localparam logic [7:0] A_IST  = 8'h3C;
  localparam logic [7:0] A_TXD  = 8'h40;
  localparam logic [7:0] A_RXD  = 8'h44;

  // Bit positions
  localparam int B_SRST     = 31;
  localparam int B_EN       = 30;
  localparam int B_FAST     = 31;
  localparam int B_FLUSH_RX = 31;
  localparam int B_FLUSH_TX = 30;
  localparam int B_EV_FULL  = 31;
  localparam int B_EV_THLD  = 30;
  localparam int B_EV_DONE  = 28;
  localparam int B_TX_LAST  = 31;
  localparam int B_START    = 31;

  // Number of interrupt sources: 0 = done, 1 = threshold, 2 = full
  localparam int N_EV = 3;

  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } tx_ent_t;

  typedef struct packed {
    logic [1:0] st;
    logic       pec;
    logic [7:0] data;
  } rx_ent_t;

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/i2cm_irq_unit.sv
module i2cm_irq_unit #(
  parameter int N = 3,
  parameter logic [N-1:0] LEVEL_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] level,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] enable,
  output logic [N-1:0] pending,
  output logic         irq
);

  logic [N-1:0] level_q;

  // One edge detector and one sticky flag per source
  for (genvar g = 0; g < N; g++) begin : g_src
    logic rise;
    assign rise = level[g] && !level_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        level_q[g] <= LEVEL_RST[g];
        pending[g] <= 1'b0;
      end else begin
        level_q[g] <= level[g];
        if (clear)                      pending[g] <= 1'b0;
        else if (rise)                  pending[g] <= 1'b1;
        else if (clr_wr && clr_mask[g]) pending[g] <= 1'b0;
      end
    end
  end

  assign irq = |(pending & enable);

endmodule

// File: rtl/i2cm_csr_bank.sv
module i2cm_csr_bank
  import i2cm_bank_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_write,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [8:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [10:0] rx_data,
  input  logic        eng_busy,
  output logic        cmd_start,
  output logic [30:0] cmd_word,
  output logic        ctl_reset,
  output logic        ctl_enable,
  output logic [3:0]  ctl_retry,
  output logic        ctl_fast,
  output logic        irq
);

  logic          wr, rd;
  logic          soft_rst;
  logic          flush_rx_q, flush_tx_q;
  logic [5:0]    thld_q;
  logic [N_EV-1:0] ie_vec, pend_vec, clr_mask, ev_level;
  logic [31:0]   sts_word, ie_word, rd_word;

  logic          tx_push, tx_pop, tx_full, tx_empty;
  logic [CW-1:0] tx_count;
  tx_ent_t       tx_din, tx_dout;

  logic          rx_push, rx_pop, rx_full, rx_empty;
  logic [CW-1:0] rx_count;
  rx_ent_t       rx_dout;

  assign host_ready = 1'b1;
  assign wr = host_valid && host_write;
  assign rd = host_valid && !host_write;

  // Configuration, timing, command, enable and threshold registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_reset  <= 1'b0;
      ctl_enable <= 1'b0;
      ctl_retry  <= '0;
      ctl_fast   <= 1'b0;
      cmd_word   <= '0;
      cmd_start  <= 1'b0;
      ie_vec     <= '0;
      thld_q     <= '0;
      flush_rx_q <= 1'b0;
      flush_tx_q <= 1'b0;
    end else begin
      cmd_start  <= 1'b0;
      flush_rx_q <= 1'b0;
      flush_tx_q <= 1'b0;
      if (wr) begin
        unique case (host_addr)
          A_CFG: begin
            ctl_reset  <= host_wdata[B_SRST];
            ctl_enable <= host_wdata[B_EN];
            ctl_retry  <= host_wdata[19:16];
          end
          A_TIM:  ctl_fast <= host_wdata[B_FAST];
          A_FCTL: begin
            flush_rx_q <= host_wdata[B_FLUSH_RX];
            flush_tx_q <= host_wdata[B_FLUSH_TX];
            thld_q     <= host_wdata[13:8];
          end
          A_CMD: begin
            cmd_word  <= host_wdata[30:0];
            cmd_start <= host_wdata[B_START];
          end
          A_IEN: ie_vec <= {host_wdata[B_EV_FULL], host_wdata[B_EV_THLD],
                            host_wdata[B_EV_DONE]};
          default: ;
        endcase
      end
    end
  end

  assign soft_rst = ctl_reset;

  // Transmit queue
  assign tx_push  = wr && (host_addr == A_TXD) && !soft_rst;
  assign tx_din   = '{last: host_wdata[B_TX_LAST], data: host_wdata[7:0]};
  assign tx_valid = !tx_empty && !soft_rst;
  assign tx_pop   = tx_valid && tx_ready;
  assign tx_data  = tx_dout;

  i2cm_fifo #(.WIDTH($bits(tx_ent_t)), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(soft_rst || flush_tx_q),
    .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  // Receive queue
  assign rx_ready = !rx_full && !soft_rst;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = rd && (host_addr == A_RXD);

  i2cm_fifo #(.WIDTH($bits(rx_ent_t)), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(soft_rst || flush_rx_q),
    .push(rx_push), .din(rx_data), .pop(rx_pop), .dout(rx_dout),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  // Interrupt events: index 0 = engine idle (busy fell), 1 = above threshold, 2 = full
  assign ev_level = {rx_full, (rx_count > CW'(thld_q)), !eng_busy};
  assign clr_mask = {host_wdata[B_EV_FULL], host_wdata[B_EV_THLD], host_wdata[B_EV_DONE]};

  i2cm_irq_unit #(.N(N_EV), .LEVEL_RST(3'b001)) u_irq (
    .clk(clk), .rst_n(rst_n), .clear(soft_rst), .level(ev_level),
    .clr_wr(wr && (host_addr == A_IST)), .clr_mask(clr_mask),
    .enable(ie_vec), .pending(pend_vec), .irq(irq)
  );

  always_comb begin
    sts_word = '0;
    sts_word[B_EV_DONE] = pend_vec[0];
    sts_word[B_EV_THLD] = pend_vec[1];
    sts_word[B_EV_FULL] = pend_vec[2];
    ie_word = '0;
    ie_word[B_EV_DONE] = ie_vec[0];
    ie_word[B_EV_THLD] = ie_vec[1];
    ie_word[B_EV_FULL] = ie_vec[2];
  end

  // Read data select
  always_comb begin
    rd_word = '0;
    unique case (host_addr)
      A_CFG: begin
        rd_word[B_SRST]  = ctl_reset;
        rd_word[B_EN]    = ctl_enable;
        rd_word[19:16]   = ctl_retry;
      end
      A_TIM:  rd_word[B_FAST] = ctl_fast;
      A_FCTL: begin
        rd_word[22:16] = 7'(rx_count);
        rd_word[13:8]  = thld_q;
      end
      A_CMD:  rd_word = {eng_busy, cmd_word};
      A_IEN:  rd_word = ie_word;
      A_IST:  rd_word = sts_word;
      A_RXD:  if (!rx_empty) rd_word = {rx_dout.st, rx_dout.pec, 21'd0, rx_dout.data};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_data  <= rd ? rd_word : '0;
    end
  end

endmodule

// File: rtl/i2cm_csr_bank_chk.sv
module i2cm_csr_bank_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_valid,
  input logic          host_write,
  input logic [7:0]    host_addr,
  input logic          rsp_valid,
  input logic [31:0]   rsp_data,
  input logic          rx_ready,
  input logic          eng_busy,
  input logic          irq,
  input logic          soft_rst,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic [31:0]   sts_word,
  input logic [31:0]   ie_word
);

  a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  a_r3_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH)) |-> !rx_ready);

  a_r6_flush_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rsp_valid && $past(host_valid && !host_write && host_addr == 8'h0C))
      |-> (rsp_data[31:30] == 2'b00));

  a_r7_busy_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(eng_busy) && !eng_busy && !soft_rst) |=> sts_word[28]);

  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_word == 32'd0) |-> !irq);

  a_r12_soft_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_count == '0 && rx_count == '0 && sts_word == 32'd0));

endmodule

bind i2cm_csr_bank i2cm_csr_bank_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
  .host_addr(host_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rx_ready(rx_ready), .eng_busy(eng_busy), .irq(irq), .soft_rst(soft_rst),
  .tx_count(tx_count), .rx_count(rx_count), .sts_word(sts_word), .ie_word(ie_word)
);

// File: tb/i2cm_csr_bank_test.sv
`timescale 1ns/1ps
module i2cm_csr_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic        tx_valid, tx_ready = 1'b0;
  logic [8:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [10:0] rx_data = '0;
  logic        eng_busy = 1'b0;
  logic        cmd_start;
  logic [30:0] cmd_word;
  logic        ctl_reset, ctl_enable, ctl_fast, irq;
  logic [3:0]  ctl_retry;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2cm_csr_bank uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    host_valid = 1; host_write = 1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_valid = 0; host_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    host_valid = 1; host_write = 0; host_addr = a;
    @(posedge clk); @(negedge clk);
    host_valid = 0;
    d = rsp_data;
  endtask

  task automatic rx_push(logic [10:0] d);
    rx_valid = 1; rx_data = d;
    @(posedge clk); @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic busy_pulse();
    eng_busy = 1; idle(1); eng_busy = 0; idle(2);
  endtask

  task automatic flush_all();
    wr(8'h0C, 32'hC000_0000); idle(2);
    wr(8'h3C, 32'hFFFF_FFFF); idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 cfg reset", v, 0);
    rd(8'h0C, v); chk("R1 fifo ctl reset", v, 0);
    rd(8'h38, v); chk("R1 enable reset", v, 0);
    rd(8'h3C, v); chk("R1 status reset", v, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 tx_valid reset", tx_valid, 0);
    chk("R1 host_ready", host_ready, 1);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h00, 32'h7FF5_FFFF); rd(8'h00, v);
    chk("R1 cfg mask", v, 32'h4005_0000);
    chk("R1 retry pin", ctl_retry, 4'h5);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v);
    chk("R1 timing mask", v, 32'h8000_0000);
    chk("R1 fast pin", ctl_fast, 1);
    wr(8'h00, 32'h4000_0000);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    int n;
    wr(8'h40, 32'h0000_0011); wr(8'h40, 32'h0000_0022); wr(8'h40, 32'h8000_0033);
    chk("R2 tx first", {tx_valid, tx_data}, {1'b1, 9'h011});
    tx_ready = 1; @(posedge clk); @(negedge clk); tx_ready = 0;
    chk("R2 tx second", {tx_valid, tx_data}, {1'b1, 9'h022});
    tx_ready = 1; @(posedge clk); @(negedge clk); tx_ready = 0;
    chk("R2 tx last marker", {tx_valid, tx_data}, {1'b1, 9'h133});
    tx_ready = 1; @(posedge clk); @(negedge clk); tx_ready = 0;
    chk("R2 tx drained", tx_valid, 0);
    for (int i = 0; i < 65; i++) wr(8'h40, i);
    n = 0; tx_ready = 1;
    for (int i = 0; i < 80; i++) begin
      if (tx_valid) n++;
      @(posedge clk); @(negedge clk);
    end
    tx_ready = 0;
    chk("R2 tx full drop count", n, 64);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    rx_push({2'b01, 1'b1, 8'hA5}); rx_push({2'b10, 1'b0, 8'h3C}); rx_push({2'b00, 1'b0, 8'hFF});
    rd(8'h0C, v); chk("R5 rx count 3", v[22:16], 3);
    rd(8'h44, v); chk("R4 rx entry 1", v, 32'h6000_00A5);
    rd(8'h44, v); chk("R4 rx entry 2", v, 32'h8000_003C);
    rd(8'h44, v); chk("R4 rx entry 3", v, 32'h0000_00FF);
    rd(8'h44, v); chk("R4 empty read", v, 0);
    rd(8'h0C, v); chk("R4 count stays 0", v[22:16], 0);
    wr(8'h0C, 32'h0000_2A00); rd(8'h0C, v);
    chk("R5 threshold rw", v, 32'h0000_2A00);
    wr(8'h0C, 32'h0000_0000);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) rx_push(11'(i));
    wr(8'h40, 32'h1); wr(8'h40, 32'h2);
    wr(8'h0C, 32'h8000_0000); idle(2);
    rd(8'h0C, v); chk("R6 rx flushed, flags read 0", v, 0);
    chk("R6 tx untouched by rx flush", tx_valid, 1);
    wr(8'h0C, 32'h4000_0000); idle(2);
    chk("R6 tx flushed", tx_valid, 0);
    rd(8'h0C, v); chk("R6 flush bits read 0", v[31:30], 0);
    wr(8'h3C, 32'hFFFF_FFFF);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    busy_pulse();
    rd(8'h3C, v); chk("R7 done bit set", v, 32'h1000_0000);
    chk("R11 irq masked", irq, 0);
    wr(8'h38, 32'h1000_0000); idle(1);
    chk("R11 irq enabled", irq, 1);
    wr(8'h3C, 32'h4000_0000); rd(8'h3C, v);
    chk("R10 other bit write keeps", v, 32'h1000_0000);
    wr(8'h3C, 32'h1000_0000); rd(8'h3C, v);
    chk("R10 w1c clears", v, 0);
    chk("R11 irq drops", irq, 0);
    wr(8'h38, 32'h0);
  endtask

  task automatic t_thld();
    logic [31:0] v;
    wr(8'h0C, 32'h0000_0200);
    rx_push(11'h1); rx_push(11'h2); idle(2);
    rd(8'h3C, v); chk("R8 at threshold no event", v[30], 0);
    rx_push(11'h3); idle(2);
    rd(8'h3C, v); chk("R8 above threshold event", v[30], 1);
    wr(8'h38, 32'h4000_0000); idle(1);
    chk("R11 irq threshold", irq, 1);
    wr(8'h38, 32'h0); wr(8'h0C, 32'h0);
    flush_all();
  endtask

  task automatic t_full();
    logic [31:0] v;
    for (int i = 0; i < 63; i++) rx_push(11'(i));
    idle(2);
    rd(8'h3C, v); chk("R9 not full at 63", v[31], 0);
    rx_push(11'h7F); idle(2);
    rd(8'h3C, v); chk("R9 full event", v[31], 1);
    chk("R3 rx_ready low", rx_ready, 0);
    rx_push(11'h55);
    rd(8'h0C, v); chk("R3 count holds 64", v[22:16], 64);
    wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, v);
    chk("R10 all ones clears", v, 0);
    flush_all();
  endtask

  task automatic t_softrst();
    logic [31:0] v;
    rx_push(11'h11); rx_push(11'h22); wr(8'h40, 32'h77); busy_pulse();
    wr(8'h00, 32'h8000_0000); idle(2);
    wr(8'h40, 32'h55);
    chk("R12 rx_ready low", rx_ready, 0);
    chk("R12 tx_valid low", tx_valid, 0);
    wr(8'h00, 32'h4000_0000); idle(2);
    chk("R12 tx write ignored", tx_valid, 0);
    rd(8'h0C, v); chk("R12 rx emptied", v[22:16], 0);
    rd(8'h3C, v); chk("R12 status cleared", v, 0);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    wr(8'h30, 32'h8000_1234);
    chk("R13 start pulse", cmd_start, 1);
    chk("R13 cmd word", cmd_word, 31'h1234);
    idle(1);
    chk("R13 pulse one cycle", cmd_start, 0);
    wr(8'h30, 32'h0000_0042); idle(1);
    chk("R13 no start when bit31 low", cmd_start, 0);
    eng_busy = 1; rd(8'h30, v); chk("R13 busy readback", v, 32'h8000_0042);
    eng_busy = 0; rd(8'h30, v); chk("R13 idle readback", v, 32'h0000_0042);
    idle(2); wr(8'h3C, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_regs();
    t_tx();
    t_rx();
    t_flush();
    t_busy();
    t_thld();
    t_full();
    t_softrst();
    t_cmd();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule